// File: doc/BRIEF.md
# Logic Self-Test Sequencer

This block runs a logic self-test on one of two processor cores. Software first fills in a small bank of configuration registers: how many test intervals to run, which core is under test, a run-time limit, a test clock divider, a start value for the interval pointer, and a flag that says whether each run starts again from that value. It then writes a 4-bit start key. Only the key value 0xA arms the test. Once armed, the sequencer holds until the selected core signals that it is idle. A software override bit can stand in for that signal.

During the run, the sequencer drives a stand-in scan engine. The engine is clocked by the divided test tick. For every interval it builds a signature, and that signature is compared against a golden value for the current interval pointer. A fault-insertion bit together with a nonzero self-check key forces a mismatch on purpose, so software can confirm that failures are reported. A down-counting watchdog limits how long the run may take. At the end the sequencer sets the done and fail status flags and clears the start key. It raises a level interrupt toward the partner core, not toward the core under test. Writing 1 to a status flag clears that flag and drops the interrupt.

There is no data stream here. Every pin is a plain control or status pin: a single-cycle register write strobe, a combinational read port, the two core idle inputs and the two interrupt outputs.

Top module: `lst_seq`

## Requirements
- R1: After reset, the status word reads 0 (done, fail, armed and running all low, pointer 0), the key field reads 0 and both interrupts are low.
- R2: Writing register 1 with bits [3:0] equal to 0xA while idle arms the test, shown by status bit 3. Any other key value is stored but leaves the sequencer idle.
- R3: While armed, the sequencer waits until core_idle[sel] is high or the override bit (register 6 bit 0) is 1. The core selected by register 1 bit 4 is the one tested. The other core's idle input has no effect. Status bit 2 shows the run.
- R4: With interval count N (register 0 bits [7:0]), SHIFT_LEN ticks per interval and divider D (register 3), one test tick occurs every D+1 cycles. A passing run ends on its N*SHIFT_LEN*(D+1)-th running cycle with done=1 (status bit 0) and fail=0 (status bit 1). The pointer in status bits [23:16] has advanced by N, and the key field reads 0.
- R5: The watchdog is loaded from register 2 at the start of the run and counts down once per running cycle. If N*SHIFT_LEN*(D+1) exceeds the preload P, the run ends on running cycle P+1 with done=1, fail=1 and key field 0. A run that needs exactly P cycles passes.
- R6: If fault insertion (register 5 bit 0) is 1 and the self-check key (register 5 bits [7:4]) is nonzero, the run ends at its normal time with fail=1. If either one is zero, the run passes.
- R7: While done is set, the interrupt is high on the partner core only: done_irq[1] when core 0 is tested, done_irq[0] when core 1 is tested.
- R8: Writing register 7 with bit 0 or bit 1 set clears done or fail respectively, and the interrupt goes low on the next cycle. Arming also clears both flags.
- R9: If the restart flag (register 0 bit 31) is 1, the pointer is loaded from register 4 when the test is armed. If it is 0, the pointer continues from where the previous run stopped.
- R10: While armed or running, writes to registers 0 through 5 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe, one write per cycle |
| cfg_addr | input | 3 | Register write address |
| cfg_wdata | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Combinational read data |
| core_idle | input | 2 | Idle indication from core 0 and core 1 |
| done_irq | output | 2 | Done interrupt toward core 0 and core 1 |

## Verification
The bench builds the sequencer with SHIFT_LEN set to 3 and keeps the default widths. This makes one interval 3*(D+1) cycles long, so a single short run can test a watchdog preload exactly at the pass limit, and one cycle below it, with preloads of 12 and 11. The same short intervals make it cheap to repeat runs on both cores. These repeated runs cover the restart and resume pointer paths, interrupt routing in both directions, and both the forced-mismatch and key-zero self-check cases.

// File: rtl/lst_pkg.sv
package lst_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_RUN} lst_state_e;

  localparam logic [2:0] A_CNT   = 3'd0;
  localparam logic [2:0] A_CTL   = 3'd1;
  localparam logic [2:0] A_TMO   = 3'd2;
  localparam logic [2:0] A_DIV   = 3'd3;
  localparam logic [2:0] A_START = 3'd4;
  localparam logic [2:0] A_SELF  = 3'd5;
  localparam logic [2:0] A_OVR   = 3'd6;
  localparam logic [2:0] A_STAT  = 3'd7;

  localparam logic [3:0] KEY_GO  = 4'hA;
endpackage

// File: rtl/lst_tick_gen.sv
module lst_tick_gen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = en && (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (!en || tick) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lst_scan_stub.sv
module lst_scan_stub #(
  parameter int PTR_W     = 8,
  parameter int SHIFT_LEN = 4,
  parameter int SIG_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [PTR_W-1:0] ptr,
  input  logic             inject,
  output logic             seg_end,
  output logic             mismatch
);
  localparam int STEP_W = (SHIFT_LEN > 2) ? $clog2(SHIFT_LEN) : 1;
  localparam logic [SIG_W-1:0] SEED = {SIG_W{1'b1}};

  function automatic logic [SIG_W-1:0] mix(input logic [SIG_W-1:0] s,
                                           input logic [PTR_W-1:0] p,
                                           input logic [STEP_W-1:0] k);
    logic [SIG_W-1:0] fb;
    fb = {s[SIG_W-2:0], s[SIG_W-1] ^ s[SIG_W-3]};
    return fb ^ SIG_W'({p, k});
  endfunction

  function automatic logic [SIG_W-1:0] golden(input logic [PTR_W-1:0] p);
    logic [SIG_W-1:0] s;
    s = SEED;
    for (int i = 0; i < SHIFT_LEN; i++) s = mix(s, p, STEP_W'(i));
    return s;
  endfunction

  logic [SIG_W-1:0]  sig_q;
  logic [STEP_W-1:0] step_q;
  logic [SIG_W-1:0]  sig_nx;

  assign sig_nx   = mix(sig_q, ptr, step_q);
  assign seg_end  = tick && (step_q == STEP_W'(SHIFT_LEN - 1));
  assign mismatch = (sig_nx != golden(ptr)) ^ inject;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q  <= SEED;
      step_q <= '0;
    end else if (!en || seg_end) begin
      sig_q  <= SEED;
      step_q <= '0;
    end else if (tick) begin
      sig_q  <= sig_nx;
      step_q <= step_q + 1'b1;
    end
  end
endmodule

// File: rtl/lst_seq.sv
module lst_seq
  import lst_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int TMO_W     = 20,
  parameter int PTR_W     = 8,
  parameter int DIV_W     = 4,
  parameter int SHIFT_LEN = 4,
  parameter int SIG_W     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  input  logic [1:0]  core_idle,
  output logic [1:0]  done_irq
);
  lst_state_e       st_q;
  logic [CNT_W-1:0] cnt_q, rem_q;
  logic             restart_q, sel_q, fault_q, ovr_q;
  logic [3:0]       key_q, chk_key_q;
  logic [TMO_W-1:0] tmo_pre_q, tmo_q;
  logic [DIV_W-1:0] div_q;
  logic [PTR_W-1:0] start_q, ptr_q;
  logic             done_q, fail_q, acc_q;
  logic             tick, seg_end, mismatch, running, idle_go, inject;
  logic             unused_wdata;

  assign unused_wdata = ^cfg_wdata;
  assign running = (st_q == ST_RUN);
  assign idle_go = core_idle[sel_q] | ovr_q;
  assign inject  = fault_q && (chk_key_q != 4'd0);

  lst_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(running), .div(div_q), .tick(tick)
  );

  lst_scan_stub #(.PTR_W(PTR_W), .SHIFT_LEN(SHIFT_LEN), .SIG_W(SIG_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .en(running), .tick(tick), .ptr(ptr_q),
    .inject(inject), .seg_end(seg_end), .mismatch(mismatch)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      cnt_q <= '0; rem_q <= '0; restart_q <= 1'b0; sel_q <= 1'b0;
      fault_q <= 1'b0; ovr_q <= 1'b0; key_q <= '0; chk_key_q <= '0;
      tmo_pre_q <= '0; tmo_q <= '0; div_q <= '0; start_q <= '0;
      ptr_q <= '0; done_q <= 1'b0; fail_q <= 1'b0; acc_q <= 1'b0;
    end else begin
      if (cfg_we && cfg_addr == A_OVR) ovr_q <= cfg_wdata[0];
      if (cfg_we && cfg_addr == A_STAT) begin
        if (cfg_wdata[0]) done_q <= 1'b0;
        if (cfg_wdata[1]) fail_q <= 1'b0;
      end
      unique case (st_q)
        ST_IDLE: if (cfg_we) begin
          unique case (cfg_addr)
            A_CNT: begin
              cnt_q     <= cfg_wdata[CNT_W-1:0];
              restart_q <= cfg_wdata[31];
            end
            A_CTL: begin
              key_q <= cfg_wdata[3:0];
              sel_q <= cfg_wdata[4];
              if (cfg_wdata[3:0] == KEY_GO) begin
                st_q   <= ST_ARMED;
                done_q <= 1'b0;
                fail_q <= 1'b0;
                if (restart_q) ptr_q <= start_q;
              end
            end
            A_TMO:   tmo_pre_q <= cfg_wdata[TMO_W-1:0];
            A_DIV:   div_q     <= cfg_wdata[DIV_W-1:0];
            A_START: start_q   <= cfg_wdata[PTR_W-1:0];
            A_SELF: begin
              fault_q   <= cfg_wdata[0];
              chk_key_q <= cfg_wdata[7:4];
            end
            default: ;
          endcase
        end
        ST_ARMED: if (idle_go) begin
          st_q  <= ST_RUN;
          tmo_q <= tmo_pre_q;
          rem_q <= cnt_q;
          acc_q <= 1'b0;
        end
        ST_RUN: begin
          if (tmo_q == '0) begin
            st_q <= ST_IDLE; done_q <= 1'b1; fail_q <= 1'b1; key_q <= '0;
          end else begin
            tmo_q <= tmo_q - 1'b1;
            if (rem_q == '0) begin
              st_q <= ST_IDLE; done_q <= 1'b1; fail_q <= acc_q; key_q <= '0;
            end else if (seg_end) begin
              ptr_q <= ptr_q + 1'b1;
              rem_q <= rem_q - 1'b1;
              acc_q <= acc_q | mismatch;
              if (rem_q == CNT_W'(1)) begin
                st_q <= ST_IDLE; done_q <= 1'b1;
                fail_q <= acc_q | mismatch; key_q <= '0;
              end
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done_irq = sel_q ? {1'b0, done_q} : {done_q, 1'b0};

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_CNT:   rd_data = {restart_q, 31'(cnt_q)};
      A_CTL:   rd_data = {27'd0, sel_q, key_q};
      A_TMO:   rd_data = 32'(tmo_pre_q);
      A_DIV:   rd_data = 32'(div_q);
      A_START: rd_data = 32'(start_q);
      A_SELF:  rd_data = {24'd0, chk_key_q, 3'd0, fault_q};
      A_OVR:   rd_data = {31'd0, ovr_q};
      A_STAT:  rd_data = {8'd0, 8'(ptr_q), 12'd0,
                          (st_q == ST_ARMED), running, fail_q, done_q};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/lst_seq_chk.sv
module lst_seq_chk
  import lst_pkg::*;
#(
  parameter int TMO_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [2:0]       cfg_addr,
  input logic [31:0]      cfg_wdata,
  input logic [1:0]       core_idle,
  input logic [1:0]       done_irq,
  input lst_state_e       st,
  input logic             sel,
  input logic             ovr,
  input logic             done,
  input logic [TMO_W-1:0] tmo_pre
);
  logic armed, running;
  assign armed   = (st == ST_ARMED);
  assign running = (st == ST_RUN);

  // R2: arming only follows a key write of 0xA
  a_r2_arm_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(cfg_we && cfg_addr == A_CTL && cfg_wdata[3:0] == KEY_GO));

  // R3: no start until the selected core is idle or overridden
  a_r3_wait_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !core_idle[sel] && !ovr) |=> armed);

  // R4: the end of a run always leaves done set
  a_r4_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> done);

  // R7: at most one core is interrupted
  a_r7_irq_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_irq));

  // R8: a clear of done while not running drops the interrupt
  a_r8_clear_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == A_STAT && cfg_wdata[0] && !running) |=> (done_irq == 2'b00));

  // R10: timeout preload holds while the test is busy
  a_r10_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    ((armed || running) && cfg_we && cfg_addr == A_TMO) |=> $stable(tmo_pre));
endmodule

bind lst_seq lst_seq_chk #(.TMO_W(TMO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .core_idle(core_idle), .done_irq(done_irq),
  .st(st_q), .sel(sel_q), .ovr(ovr_q), .done(done_q), .tmo_pre(tmo_pre_q)
);

// File: tb/lst_seq_tb.sv
`timescale 1ns/1ps
module lst_seq_tb;
  localparam int S = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [2:0]  rd_addr = 3'd7;
  logic [31:0] rd_data;
  logic [1:0]  core_idle = 2'b00;
  logic [1:0]  done_irq;

  int checks = 0, fails = 0;

  // reference model state
  int m_st = 0, m_cnt = 0, m_rst = 0, m_key = 0, m_sel = 0, m_tmo = 0;
  int m_div = 0, m_start = 0, m_fault = 0, m_ck = 0, m_ovr = 0;
  int m_done = 0, m_fail = 0, m_ptr = 0, m_left = 0, m_c = 0, m_iv = 0;

  always #2.5 clk = ~clk;

  lst_seq #(.SHIFT_LEN(S)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .core_idle(core_idle), .done_irq(done_irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run(int f);
    m_st = 0; m_done = 1; m_fail = f; m_key = 0;
  endtask

  task automatic model_update();
    int inj;
    inj = (m_fault != 0 && m_ck != 0) ? 1 : 0;
    if (cfg_we && cfg_addr == 3'd6) m_ovr = cfg_wdata[0];
    if (cfg_we && cfg_addr == 3'd7) begin
      if (cfg_wdata[0]) m_done = 0;
      if (cfg_wdata[1]) m_fail = 0;
    end
    case (m_st)
      0: if (cfg_we) begin
        case (cfg_addr)
          3'd0: begin m_cnt = cfg_wdata[7:0]; m_rst = cfg_wdata[31]; end
          3'd1: begin
            m_key = cfg_wdata[3:0]; m_sel = cfg_wdata[4];
            if (cfg_wdata[3:0] == 4'hA) begin
              m_st = 1; m_done = 0; m_fail = 0;
              if (m_rst != 0) m_ptr = m_start;
            end
          end
          3'd2: m_tmo = cfg_wdata[19:0];
          3'd3: m_div = cfg_wdata[3:0];
          3'd4: m_start = cfg_wdata[7:0];
          3'd5: begin m_fault = cfg_wdata[0]; m_ck = cfg_wdata[7:4]; end
          default: ;
        endcase
      end
      1: if (core_idle[m_sel] || m_ovr != 0) begin
        m_st = 2; m_left = m_tmo; m_c = 0; m_iv = 0;
      end
      default: begin
        m_c++;
        if (m_left == 0) finish_run(1);
        else begin
          m_left--;
          if (m_cnt == 0) finish_run(0);
          else if (m_c % (S * (m_div + 1)) == 0) begin
            m_ptr = (m_ptr + 1) % 256; m_iv++;
            if (m_iv == m_cnt) finish_run(inj);
          end
        end
      end
    endcase
  endtask

  task automatic compare();
    logic [1:0] eirq;
    eirq = (m_done == 0) ? 2'b00 : (m_sel != 0 ? 2'b01 : 2'b10);
    check("R7", 32'(done_irq), 32'(eirq));
    if (rd_addr == 3'd7) begin
      check("R4", 32'(rd_data[0]), 32'(m_done));
      check("R6", 32'(rd_data[1]), 32'(m_fail));
      check("R3", 32'(rd_data[2]), 32'(m_st == 2));
      check("R2", 32'(rd_data[3]), 32'(m_st == 1));
      check("R9", 32'(rd_data[23:16]), 32'(m_ptr));
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    #1;
    compare();
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    rd_addr = a; #0.5;
    d = rd_data;
    rd_addr = 3'd7; #0.5;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 2000 && m_st != 0; i++) step();
    step();
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL R4 watchdog expired actual=%h expected=%h", 0, 1);
    report();
    $finish;
  end

  initial begin
    logic [31:0] v;
    #12;
    compare();
    rd(3'd1, v); check("R1", v, 32'h0);
    rd(3'd7, v); check("R1", v, 32'h0);
    check("R1", 32'(done_irq), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    step();

    // R2: wrong key stays idle
    wr(3'd1, 32'h5);
    step();
    rd(3'd7, v); check("R2", 32'(v[3]), 32'h0);
    rd(3'd1, v); check("R2", v, 32'h5);

    // first run on core 0, restart from 0x10
    wr(3'd0, 32'h8000_0002);
    wr(3'd2, 32'h18E2E);
    wr(3'd3, 32'h1);
    wr(3'd4, 32'h10);
    wr(3'd5, 32'h0);
    wr(3'd1, 32'h0A);
    rd(3'd7, v); check("R2", 32'(v[3]), 32'h1);
    core_idle = 2'b10;
    repeat (5) step();
    rd(3'd7, v); check("R3", 32'(v[3:2]), 32'h2);
    wr(3'd2, 32'h5);
    core_idle = 2'b01;
    wait_done();
    core_idle = 2'b00;
    rd(3'd7, v);
    check("R4", 32'(v[1:0]), 32'h1);
    check("R4", 32'(v[23:16]), 32'h12);
    check("R7", 32'(done_irq), 32'h2);
    rd(3'd1, v); check("R4", v, 32'h0);
    rd(3'd2, v); check("R10", v, 32'h18E2E);

    // R8: write-one-to-clear
    wr(3'd7, 32'h3);
    step();
    check("R8", 32'(done_irq), 32'h0);
    rd(3'd7, v); check("R8", 32'(v[1:0]), 32'h0);

    // R9: resume without restart, core 1, override idle
    wr(3'd0, 32'h3);
    wr(3'd3, 32'h0);
    wr(3'd6, 32'h1);
    wr(3'd1, 32'h1A);
    wait_done();
    rd(3'd7, v); check("R9", 32'(v[23:16]), 32'h15);
    check("R7", 32'(done_irq), 32'h1);
    wr(3'd6, 32'h0);

    // R6: forced mismatch
    wr(3'd5, 32'h31);
    wr(3'd0, 32'h8000_0001);
    core_idle = 2'b01;
    wr(3'd1, 32'h0A);
    wait_done();
    rd(3'd7, v);
    check("R6", 32'(v[1:0]), 32'h3);
    check("R9", 32'(v[23:16]), 32'h11);

    // R6: key zero disables injection
    wr(3'd5, 32'h01);
    wr(3'd1, 32'h0A);
    wait_done();
    rd(3'd7, v); check("R6", 32'(v[1:0]), 32'h1);

    // R5: preload exactly equal to need passes (2*3*2 = 12)
    wr(3'd5, 32'h0);
    wr(3'd0, 32'h8000_0002);
    wr(3'd3, 32'h1);
    wr(3'd2, 32'd12);
    wr(3'd1, 32'h0A);
    wait_done();
    rd(3'd7, v); check("R5", 32'(v[1:0]), 32'h1);

    // R5: one cycle short times out
    wr(3'd2, 32'd11);
    wr(3'd1, 32'h0A);
    wait_done();
    rd(3'd7, v);
    check("R5", 32'(v[1:0]), 32'h3);
    check("R5", 32'(v[23:16]), 32'h11);
    rd(3'd1, v); check("R5", 32'(v[3:0]), 32'h0);

    // R5: very short preload
    wr(3'd2, 32'd4);
    wr(3'd1, 32'h0A);
    wait_done();
    rd(3'd7, v);
    check("R5", 32'(v[1:0]), 32'h3);
    check("R5", 32'(v[23:16]), 32'h10);
    core_idle = 2'b00;
    repeat (3) step();

    report();
    $finish;
  end
endmodule